// File: doc/BRIEF.md
# Burst Address Sequencer for a Wishbone Slave

This block sits between a Wishbone master and a memory-like slave. It watches each bus cycle and produces the word address that belongs to every beat. The cycle-type and burst-type sidebands of the master tell it how the address moves from beat to beat. In a constant burst the address does not change. In a linear burst it steps by one word. In a wrapping burst it steps inside an aligned window of 4, 8 or 16 words. A single parameter selects one of two handshakes: the stall-based pipelined handshake or the classic handshake.

Each beat drives four outputs: a beat-accepted strobe, a write qualifier, an end-of-burst flag and the beat address. The block also drives ACK back to the master. When no burst is open, the beat address is the master's own address. While a burst is open, the beat address is the sequencer's prediction for that beat.

Top module: `burst_addr_seq`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and on the first cycle after it is released, `ackOut` is 0 and the block is idle, so `beatAddr` equals `adrIn`.
- R2: With PIPELINED=1, `beatValid` equals `cycIn & stbIn & ~stallIn`. `beatWrite` equals `beatValid & weIn`.
- R3: With PIPELINED=1, `ackOut` is high in the clock that follows each accepted beat, and low in the clock that follows a cycle with no accepted beat.
- R4: With PIPELINED=0, `ackOut` rises one clock after `cycIn & stbIn` is seen while `ackOut` is low, and is then low for one clock. `beatValid` equals `cycIn & stbIn & ackOut`. `stallIn` has no effect.
- R5: While idle, `beatAddr` equals `adrIn` combinationally.
- R6: An accepted beat with `ctiIn`=1 (constant burst) opens or continues a burst. Every later beat of that burst has the same address as this beat.
- R7: An accepted beat with `ctiIn`=2 (incrementing) and `bteIn`=0 (linear) makes the next beat address one higher. The address wraps modulo 2^ADDR_W.
- R8: An accepted beat with `ctiIn`=2 and `bteIn`=1, 2 or 3 advances only the low 2, 3 or 4 address bits, modulo 4, 8 or 16. All upper bits keep their value from the first beat.
- R9: An accepted beat with any `ctiIn` other than 1 or 2 sets `beatLast`. This covers 0 (classic), 7 (end of burst) and the reserved codes 3 to 6. The block then returns to idle, so the next beat takes a fresh address from `adrIn`.
- R10: If `cycIn` is low in any clock, the block is idle from the next clock on.
- R11: During an open burst, an accepted beat is expected to present on `adrIn` the address the block predicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycIn | input | 1 | Master bus cycle active |
| stbIn | input | 1 | Master strobe |
| weIn | input | 1 | Master write enable |
| stallIn | input | 1 | Slave stall (pipelined mode only) |
| adrIn | input | ADDR_W | Master word address |
| ctiIn | input | 3 | Cycle type: 0 classic, 1 constant, 2 incrementing, 7 end |
| bteIn | input | 2 | Burst type: 0 linear, 1 wrap 4, 2 wrap 8, 3 wrap 16 |
| ackOut | output | 1 | Acknowledge to the master |
| beatAddr | output | ADDR_W | Address of the current beat |
| beatValid | output | 1 | Beat accepted this clock |
| beatWrite | output | 1 | Accepted beat is a write |
| beatLast | output | 1 | Accepted beat closes the burst |

## Verification
The prediction check assumes the master behaves correctly inside an open burst. It expects the master to present exactly the address that the cycle type and burst type imply, and to keep `cycIn`, `stbIn` and the sidebands steady while a classic beat waits for its acknowledge. The bench builds every beat address from the start address with its own modular arithmetic and drives that same value onto `adrIn`, so it never breaks these assumptions. Bursts are opened only with cycle type 1 or 2 and are left either with an end beat or with a clean drop of `cycIn`.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // cycle-type codes
  localparam logic [2:0] CT_CLASSIC = 3'd0;
  localparam logic [2:0] CT_CONST   = 3'd1;
  localparam logic [2:0] CT_INCR    = 3'd2;
  localparam logic [2:0] CT_END     = 3'd7;

  // burst-type codes
  localparam logic [1:0] BT_LINEAR = 2'd0;
  localparam logic [1:0] BT_WRAP4  = 2'd1;
  localparam logic [1:0] BT_WRAP8  = 2'd2;
  localparam logic [1:0] BT_WRAP16 = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       holdAddr;   // accepted constant beat: keep its address
    logic       stepAddr;   // accepted incrementing beat: advance
    logic [1:0] wrapSel;    // burst-type of the accepted beat
    logic       inBurst;    // a burst is open, use predicted address
  } seqStrobe_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter bit PIPELINED = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cycIn,
  input  logic       stbIn,
  input  logic       weIn,
  input  logic       stallIn,
  input  logic [2:0] ctiIn,
  input  logic [1:0] bteIn,
  output logic       ackOut,
  output logic       beatValid,
  output logic       beatWrite,
  output logic       beatLast,
  output seqStrobe_t strobe
);

  logic inBurst;
  logic ackReg;
  logic accept;
  logic ackNext;
  logic endsBurst;

  generate
    if (PIPELINED) begin : g_pipe
      // stall is only meaningful inside a cycle
      logic stallSeen;
      assign stallSeen = cycIn & stallIn;
      assign accept    = cycIn & stbIn & ~stallSeen;
      assign ackNext   = accept;

      // R3: acknowledge follows every accepted beat by one clock
      a_r3_ack_follows: assert property (@(posedge clk) disable iff (rst)
        accept |=> ackReg);
      a_r3_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !ackReg);
    end else begin : g_classic
      logic unusedStall;
      assign unusedStall = stallIn;
      assign accept      = cycIn & stbIn & ackReg;
      assign ackNext     = cycIn & stbIn & ~ackReg;

      // R4: classic acknowledge is a single-clock pulse
      a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ackReg |=> !ackReg);
    end
  endgenerate

  always_comb begin
    endsBurst       = (ctiIn != CT_CONST) && (ctiIn != CT_INCR);
    strobe.holdAddr = accept && (ctiIn == CT_CONST);
    strobe.stepAddr = accept && (ctiIn == CT_INCR);
    strobe.wrapSel  = bteIn;
    strobe.inBurst  = inBurst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inBurst <= 1'b0;
      ackReg  <= 1'b0;
    end else begin
      ackReg <= ackNext;
      if (!cycIn)
        inBurst <= 1'b0;
      else if (accept)
        inBurst <= !endsBurst;
    end
  end

  assign ackOut    = ackReg;
  assign beatValid = accept;
  assign beatWrite = accept & weIn;
  assign beatLast  = accept & endsBurst;

  // R10: dropping the cycle closes any burst
  a_r10_cyc_drop: assert property (@(posedge clk) disable iff (rst)
    !cycIn |=> !inBurst);
  // R9: a closing beat returns to idle
  a_r9_close_idle: assert property (@(posedge clk) disable iff (rst)
    (accept && endsBurst) |=> !inBurst);
  // R6: a constant beat keeps the burst open
  a_r6_const_opens: assert property (@(posedge clk) disable iff (rst)
    (accept && ctiIn == CT_CONST) |=> inBurst);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8    // must be at least 5 for the 16-beat window
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] adrIn,
  input  seqStrobe_t        strobe,
  output logic [ADDR_W-1:0] beatAddr
);

  localparam int NUM_WRAP = 3;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] linNext;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] wrapNext [NUM_WRAP];

  assign beatAddr = strobe.inBurst ? curAddr : adrIn;
  assign linNext  = beatAddr + ADDR_W'(1);

  // window of 2^(k+2) words: low bits advance, upper bits held
  generate
    for (genvar k = 0; k < NUM_WRAP; k++) begin : g_wrap
      localparam int LW = k + 2;
      assign wrapNext[k] = {beatAddr[ADDR_W-1:LW], beatAddr[LW-1:0] + LW'(1)};
    end
  endgenerate

  always_comb begin
    case (strobe.wrapSel)
      BT_WRAP4:  stepped = wrapNext[0];
      BT_WRAP8:  stepped = wrapNext[1];
      BT_WRAP16: stepped = wrapNext[2];
      default:   stepped = linNext;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      curAddr <= '0;
    else if (strobe.holdAddr)
      curAddr <= beatAddr;
    else if (strobe.stepAddr)
      curAddr <= stepped;
  end

  // R6: constant burst keeps the address
  a_r6_hold_addr: assert property (@(posedge clk) disable iff (rst)
    strobe.holdAddr |=> curAddr == $past(beatAddr));
  // R8: wrapping keeps the bits above the window
  a_r8_wrap4_upper: assert property (@(posedge clk) disable iff (rst)
    (strobe.stepAddr && strobe.wrapSel == BT_WRAP4)
      |=> curAddr[ADDR_W-1:2] == $past(beatAddr[ADDR_W-1:2]));
  a_r8_wrap16_upper: assert property (@(posedge clk) disable iff (rst)
    (strobe.stepAddr && strobe.wrapSel == BT_WRAP16)
      |=> curAddr[ADDR_W-1:4] == $past(beatAddr[ADDR_W-1:4]));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycIn,
  input  logic              stbIn,
  input  logic              weIn,
  input  logic              stallIn,
  input  logic [ADDR_W-1:0] adrIn,
  input  logic [2:0]        ctiIn,
  input  logic [1:0]        bteIn,
  output logic              ackOut,
  output logic [ADDR_W-1:0] beatAddr,
  output logic              beatValid,
  output logic              beatWrite,
  output logic              beatLast
);

  seqStrobe_t strobe;

  burst_seq_ctrl #(.PIPELINED(PIPELINED)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cycIn    (cycIn),
    .stbIn    (stbIn),
    .weIn     (weIn),
    .stallIn  (stallIn),
    .ctiIn    (ctiIn),
    .bteIn    (bteIn),
    .ackOut   (ackOut),
    .beatValid(beatValid),
    .beatWrite(beatWrite),
    .beatLast (beatLast),
    .strobe   (strobe)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .adrIn   (adrIn),
    .strobe  (strobe),
    .beatAddr(beatAddr)
  );

  // R11: the master's address inside a burst matches the prediction
  a_r11_predict: assert property (@(posedge clk) disable iff (rst)
    (strobe.inBurst && beatValid) |-> adrIn == beatAddr);

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int ClkPeriod = 10;
  localparam int AW = 8;
  localparam int Limit = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc [2], stb [2], we [2], stall [2];
  logic [AW-1:0] adr [2];
  logic [2:0] cti [2];
  logic [1:0] bte [2];
  logic ack [2], bValid [2], bWrite [2], bLast [2];
  logic [AW-1:0] bAddr [2];

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  // index 1: pipelined, index 0: classic
  generate
    for (genvar m = 0; m < 2; m++) begin : g_mode
      burst_addr_seq #(.ADDR_W(AW), .PIPELINED(m == 1)) i_burst_addr_seq (
        .clk(clk), .rst(rst), .cycIn(cyc[m]), .stbIn(stb[m]), .weIn(we[m]),
        .stallIn(stall[m]), .adrIn(adr[m]), .ctiIn(cti[m]), .bteIn(bte[m]),
        .ackOut(ack[m]), .beatAddr(bAddr[m]), .beatValid(bValid[m]),
        .beatWrite(bWrite[m]), .beatLast(bLast[m]));
    end
  endgenerate

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nxt(input int a, input int bt);
    int n;
    if (bt == 0) return (a + 1) & 255;
    n = (bt == 1) ? 4 : (bt == 2) ? 8 : 16;
    return (a & ~(n - 1)) | ((a + 1) & (n - 1));
  endfunction

  task automatic drive(input int m, input int a, input int ct, input int bt, input bit w);
    cyc[m] = 1'b1; stb[m] = 1'b1; we[m] = w;
    adr[m] = a[AW-1:0]; cti[m] = ct[2:0]; bte[m] = bt[1:0];
    stall[m] = (m == 0);   // classic: stall held high, must be ignored
  endtask

  task automatic beat(input int m, input int a, input int ct, input int bt,
                      input bit w, input int expAddr, input bit expLast, input string tag);
    if (m == 1) begin
      @(negedge clk); drive(m, a, ct, bt, w);
      #1;
      chk({tag, " addr"}, bAddr[m], expAddr);
      chk("R2 valid", bValid[m], 1);
      chk("R2 write", bWrite[m], w);
      chk({tag, " last"}, bLast[m], expLast);
      @(posedge clk); #1;
      chk("R3 ack after beat", ack[m], 1);
    end else begin
      @(negedge clk); drive(m, a, ct, bt, w);
      #1;
      chk("R4 no beat before ack", bValid[m], 0);
      chk({tag, " addr wait"}, bAddr[m], expAddr);
      @(posedge clk); #1;
      chk("R4 ack rises", ack[m], 1);
      @(negedge clk); #1;
      chk("R4 valid with ack", bValid[m], 1);
      chk("R4 write", bWrite[m], w);
      chk({tag, " addr"}, bAddr[m], expAddr);
      chk({tag, " last"}, bLast[m], expLast);
      @(posedge clk); #1;
      chk("R4 ack single pulse", ack[m], 0);
    end
  endtask

  task automatic idle(input int m, input int x);
    @(negedge clk);
    cyc[m] = 1'b0; stb[m] = 1'b0; adr[m] = x[AW-1:0];
    #1;
    chk("R5 idle addr follows input", bAddr[m], x);
    chk("R5 no beat when idle", bValid[m], 0);
    @(posedge clk);
  endtask

  task automatic burst(input int m, input int s, input int kind, input int bt,
                       input int len, input bit w, input string tag);
    int e = s;
    for (int i = 0; i < len; i++) begin
      beat(m, e, (i == len - 1) ? 7 : kind, bt, w, e, (i == len - 1), tag);
      if (kind == 2) e = nxt(e, bt);
    end
    // R9: after end of burst a fresh address is taken
    beat(m, (s + 77) & 255, 0, 0, w, (s + 77) & 255, 1'b1, "R9 fresh after end");
    idle(m, (s + 3) & 255);
  endtask

  initial begin : watchdog
    repeat (Limit) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", Limit, 0);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin : stim
    for (int m = 0; m < 2; m++) begin
      cyc[m] = 0; stb[m] = 0; we[m] = 0; stall[m] = 0;
      adr[m] = 8'h5A; cti[m] = 0; bte[m] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R1 ack clear in reset", ack[m], 0);
      chk("R1 idle in reset", bAddr[m], 8'h5A);
    end
    rst = 1'b0;
    @(posedge clk); #1;
    for (int m = 0; m < 2; m++) begin
      chk("R1 ack clear after reset", ack[m], 0);
      chk("R1 idle after reset", bAddr[m], 8'h5A);
    end

    for (int m = 0; m < 2; m++) begin
      // R2/R3: stalled beat is not accepted (pipelined only)
      if (m == 1) begin
        @(negedge clk); drive(m, 10, 2, 0, 1'b0); stall[m] = 1'b1;
        #1; chk("R2 stalled no beat", bValid[m], 0);
        @(posedge clk); #1; chk("R3 no ack after stall", ack[m], 0);
        beat(m, 10, 7, 0, 1'b0, 10, 1'b1, "R9 end after stall");
        idle(m, 0);
      end
      // R7/R8: incrementing bursts, all burst types, many starts
      for (int bt = 0; bt < 4; bt++)
        for (int s = 0; s < 256; s += 5)
          burst(m, s, 2, bt, 17, s[0], (bt == 0) ? "R7 linear" : "R8 wrap");
      // R6: constant bursts
      for (int s = 0; s < 256; s += 37)
        burst(m, s, 1, s & 3, 5, s[1], "R6 const");
      // R9: classic and reserved codes close at once
      beat(m, 200, 0, 0, 1'b1, 200, 1'b1, "R9 classic single");
      beat(m, 201, 3, 1, 1'b0, 201, 1'b1, "R9 reserved code");
      beat(m, 40, 2, 0, 1'b0, 40, 1'b0, "R9 open after reserved");
      beat(m, 41, 7, 0, 1'b0, 41, 1'b1, "R9 end");
      // R10: cycle dropped mid-burst
      beat(m, 60, 2, 2, 1'b1, 60, 1'b0, "R10 pre-drop");
      beat(m, 61, 2, 2, 1'b1, 61, 1'b0, "R10 pre-drop");
      @(negedge clk); cyc[m] = 1'b0; stb[m] = 1'b0;
      @(posedge clk);
      beat(m, 150, 0, 0, 1'b0, 150, 1'b1, "R10 fresh after drop");
      idle(m, 9);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule